// File: doc/BRIEF.md
# Ethernet Transceiver Power-State Controller

This block decides the power state of an Ethernet transceiver. Three sources can request power-down: a level from the management register file (the general power-down bit), an energy-detect enable combined with a line-energy indication from the squelch path, and a dedicated hardware power-down pin. The block turns these requests into enables for the PLL, the receive/transmit datapath and the line transmitter, and into an internal logic reset. Every return from a power-down state passes through a reset-stretch interval, so the PLL can settle before the logic is released. The management interface and the register contents are outside this block and stay powered and intact in every state.

A single state register holds one of five states: ACTIVE (normal operation), GEN_PD (register-requested power-down), ED_PD (no line energy while energy-detect is enabled), HW_PD (pin-requested power-down) and RESET_STRETCH (PLL running, logic held in reset for a fixed count). The named transitions are: PIN_ENTER (any state to HW_PD while the pin is high), BIT_ENTER (ACTIVE, ED_PD or RESET_STRETCH to GEN_PD while the bit is set), QUIET_ENTER (ACTIVE to ED_PD), PIN_RELEASE (HW_PD to GEN_PD), BIT_EXIT (GEN_PD to RESET_STRETCH), WAKE (ED_PD to RESET_STRETCH) and SETTLED (RESET_STRETCH to ACTIVE). A wake from energy-detect power-down sets a sticky energy status and, when unmasked, a level interrupt that a read-strobe clears.

The strap that chooses whether the PLL stops in HW_PD is captured only while the hardware reset input is low. Leaving power-down never captures it again. The stretch length is a parameter, derived by default from the clock frequency in MHz times the settle time in microseconds.

Top module: `phy_pwr_ctrl`

## Requirements
- R1: `state_o` encodes ACTIVE=0, GEN_PD=1, ED_PD=2, HW_PD=3, RESET_STRETCH=4. When `rst_n` is low and `hw_pd_pin_i` is low, the block enters RESET_STRETCH, and it is in that state in the first cycle after release.
- R2: Requests are ranked pin first, then the power-down bit, then energy-detect. A high pin moves any state to HW_PD at the next edge. A set bit moves ACTIVE, ED_PD or RESET_STRETCH to GEN_PD. ACTIVE goes to ED_PD when `ed_en_i` is 1 and `line_energy_i` is 0.
- R3: Outputs by state. ACTIVE: PLL, datapath and transmitter enabled, `logic_rst_o` low. GEN_PD and ED_PD: all three disabled. RESET_STRETCH: only the PLL enabled. `logic_rst_o` is high in every state except ACTIVE.
- R4: ACTIVE is entered only from RESET_STRETCH. It is entered after exactly `STRETCH_CYCLES` consecutive cycles in that state.
- R5: GEN_PD holds while the bit stays set. When GEN_PD was entered by BIT_ENTER, clearing the bit leads to RESET_STRETCH at the next edge.
- R6: In ED_PD, a high `line_energy_i` causes WAKE. Clearing `ed_en_i` also leaves ED_PD for RESET_STRETCH. ACTIVE is kept for as long as energy is present.
- R7: `energy_on_o` is set by a WAKE caused by line energy and stays set until a `status_rd_i` strobe clears it. If a WAKE and a strobe come in the same cycle, the WAKE wins. Leaving ED_PD because the enable was cleared does not set the status.
- R8: `irq_o` equals `energy_on_o` AND `irq_en_i`, with no delay.
- R9: Releasing the pin moves HW_PD to GEN_PD. GEN_PD is then left only after `pd_bit_i` is seen falling from 1 to 0 while in GEN_PD.
- R10: With the strap captured as 1, HW_PD disables the PLL, and leaving GEN_PD also needs a `soft_rst_i` pulse at some point after HW_PD was entered. With the strap captured as 0, the PLL stays enabled in HW_PD and no software reset is needed.
- R11: If the pin is high while `rst_n` is low, the block leaves reset in HW_PD, with the same exit rules as R9 and R10.
- R12: `strap_pll_off_i` is sampled only while `rst_n` is low. A change on it afterwards has no effect on `pll_en_o` in HW_PD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous hardware reset, active low; strap capture window |
| pd_bit_i | input | 1 | General power-down register bit (level) |
| ed_en_i | input | 1 | Energy-detect power-down enable (level) |
| line_energy_i | input | 1 | Valid line energy from the squelch path |
| hw_pd_pin_i | input | 1 | Hardware power-down pin, active high |
| strap_pll_off_i | input | 1 | Strap: 1 stops the PLL in HW_PD |
| soft_rst_i | input | 1 | Software reset pulse |
| irq_en_i | input | 1 | Energy-status interrupt mask bit |
| status_rd_i | input | 1 | Read-to-clear strobe for the energy status |
| pll_en_o | output | 1 | PLL enable |
| dp_en_o | output | 1 | Datapath enable |
| tx_en_o | output | 1 | Transmitter enable |
| logic_rst_o | output | 1 | Internal logic reset, active high |
| energy_on_o | output | 1 | Sticky energy-present status |
| irq_o | output | 1 | Level interrupt |
| state_o | output | 3 | Current state encoding |

## Verification
The bench targets the two-step exit from pin power-down. A design that treats a bit already at zero as a clear leaves GEN_PD early. A design that forgets the software-reset gate under the PLL-off strap exits without it. The bench counts the stretch cycles exactly, which catches a counter that is off by one and so releases the logic a cycle early or late. It also checks the WAKE-versus-read-strobe collision, an enable-driven exit that must leave the status clear, and a strap changed after reset that a design re-capturing it would follow. Random stimulus drives overlapping requests against a priority model, which exposes any mis-ranking between the pin, the bit and energy-detect.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    // Encoding is visible on state_o and is relied on by software and the bench.
    typedef enum logic [2:0] {
        ST_ACTIVE  = 3'd0,
        ST_GEN_PD  = 3'd1,
        ST_ED_PD   = 3'd2,
        ST_HW_PD   = 3'd3,
        ST_STRETCH = 3'd4
    } pwr_state_e;

    localparam int STATE_W = 3;

    typedef struct packed {
        logic pll;
        logic dp;
        logic tx;
        logic rst;
    } pwr_en_t;

endpackage

// File: rtl/pwr_stretch_timer.sv
// Counts cycles spent in the reset-stretch state and flags the last one.
module pwr_stretch_timer #(
    parameter int CYCLES = 32000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Asserted during the CYCLES-th consecutive cycle of run_i.
    assign done_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/pwr_exit_guard.sv
// Holds the conditions that gate leaving GEN_PD after a pin power-down:
// the strap captured at hardware reset, the pending bit-clear step and
// the pending software reset.
module pwr_exit_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_i,
    input  logic pin_i,
    input  logic enter_hw_i,
    input  logic in_gen_i,
    input  logic pd_bit_i,
    input  logic soft_rst_i,
    output logic strap_q_o,
    output logic wait_clr_o,
    output logic need_srst_o
);
    logic pd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            // Strap is captured only in this window.
            strap_q_o   <= strap_i;
            wait_clr_o  <= pin_i;
            need_srst_o <= pin_i & strap_i;
            pd_q        <= 1'b0;
        end else begin
            pd_q <= pd_bit_i;
            if (enter_hw_i) begin
                wait_clr_o  <= 1'b1;
                need_srst_o <= strap_q_o;
            end else begin
                // A 1->0 step of the bit counts only once in GEN_PD.
                if (in_gen_i && pd_q && !pd_bit_i) begin
                    wait_clr_o <= 1'b0;
                end
                if (soft_rst_i) begin
                    need_srst_o <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/pwr_energy_irq.sv
// Sticky energy status with read-to-clear and a masked level interrupt.
module pwr_energy_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_i,
    input  logic status_rd_i,
    input  logic irq_en_i,
    output logic energy_on_o,
    output logic irq_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            energy_on_o <= 1'b0;
        end else if (wake_i) begin
            energy_on_o <= 1'b1;
        end else if (status_rd_i) begin
            energy_on_o <= 1'b0;
        end
    end

    assign irq_o = energy_on_o & irq_en_i;

endmodule

// File: rtl/phy_pwr_ctrl.sv
module phy_pwr_ctrl
    import pwr_pkg::*;
#(
    parameter int CLK_MHZ        = 125,
    parameter int STRETCH_US     = 256,
    parameter int STRETCH_CYCLES = CLK_MHZ * STRETCH_US
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_bit_i,
    input  logic               ed_en_i,
    input  logic               line_energy_i,
    input  logic               hw_pd_pin_i,
    input  logic               strap_pll_off_i,
    input  logic               soft_rst_i,
    input  logic               irq_en_i,
    input  logic               status_rd_i,
    output logic               pll_en_o,
    output logic               dp_en_o,
    output logic               tx_en_o,
    output logic               logic_rst_o,
    output logic               energy_on_o,
    output logic               irq_o,
    output logic [STATE_W-1:0] state_o
);

    pwr_state_e state_q, state_d;
    pwr_en_t    en;

    logic stretch_done;
    logic strap_pll_off;
    logic wait_clr;
    logic need_srst;
    logic enter_hw;
    logic wake;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= hw_pd_pin_i ? ST_HW_PD : ST_STRETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (hw_pd_pin_i)                     state_d = ST_HW_PD;   // PIN_ENTER
                else if (pd_bit_i)                   state_d = ST_GEN_PD;  // BIT_ENTER
                else if (ed_en_i && !line_energy_i)  state_d = ST_ED_PD;   // QUIET_ENTER
            end
            ST_GEN_PD: begin
                if (hw_pd_pin_i)                     state_d = ST_HW_PD;
                else if (!pd_bit_i && !wait_clr && !need_srst)
                                                     state_d = ST_STRETCH; // BIT_EXIT
            end
            ST_ED_PD: begin
                if (hw_pd_pin_i)                     state_d = ST_HW_PD;
                else if (pd_bit_i)                   state_d = ST_GEN_PD;
                else if (line_energy_i || !ed_en_i)  state_d = ST_STRETCH; // WAKE
            end
            ST_HW_PD: begin
                if (!hw_pd_pin_i)                    state_d = ST_GEN_PD;  // PIN_RELEASE
            end
            ST_STRETCH: begin
                if (hw_pd_pin_i)                     state_d = ST_HW_PD;
                else if (pd_bit_i)                   state_d = ST_GEN_PD;
                else if (stretch_done)               state_d = ST_ACTIVE;  // SETTLED
            end
            default:                                 state_d = ST_STRETCH;
        endcase
    end

    assign enter_hw = (state_d == ST_HW_PD) && (state_q != ST_HW_PD);
    assign wake     = (state_q == ST_ED_PD) && (state_d == ST_STRETCH) && line_energy_i;

    // ---------------- output decode ----------------
    always_comb begin
        en = '{pll: 1'b0, dp: 1'b0, tx: 1'b0, rst: 1'b1};
        unique case (state_q)
            ST_ACTIVE:  en = '{pll: 1'b1, dp: 1'b1, tx: 1'b1, rst: 1'b0};
            ST_GEN_PD:  en = '{pll: 1'b0, dp: 1'b0, tx: 1'b0, rst: 1'b1};
            ST_ED_PD:   en = '{pll: 1'b0, dp: 1'b0, tx: 1'b0, rst: 1'b1};
            ST_HW_PD:   en = '{pll: !strap_pll_off, dp: 1'b0, tx: 1'b0, rst: 1'b1};
            ST_STRETCH: en = '{pll: 1'b1, dp: 1'b0, tx: 1'b0, rst: 1'b1};
            default:    en = '{pll: 1'b0, dp: 1'b0, tx: 1'b0, rst: 1'b1};
        endcase
    end

    assign pll_en_o    = en.pll;
    assign dp_en_o     = en.dp;
    assign tx_en_o     = en.tx;
    assign logic_rst_o = en.rst;
    assign state_o     = state_q;

    // ---------------- sub-blocks ----------------
    pwr_stretch_timer #(
        .CYCLES (STRETCH_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_STRETCH),
        .done_o (stretch_done)
    );

    pwr_exit_guard u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (strap_pll_off_i),
        .pin_i       (hw_pd_pin_i),
        .enter_hw_i  (enter_hw),
        .in_gen_i    (state_q == ST_GEN_PD),
        .pd_bit_i    (pd_bit_i),
        .soft_rst_i  (soft_rst_i),
        .strap_q_o   (strap_pll_off),
        .wait_clr_o  (wait_clr),
        .need_srst_o (need_srst)
    );

    pwr_energy_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake_i      (wake),
        .status_rd_i (status_rd_i),
        .irq_en_i    (irq_en_i),
        .energy_on_o (energy_on_o),
        .irq_o       (irq_o)
    );

endmodule

// File: rtl/pwr_ctrl_chk.sv
module pwr_ctrl_chk
    import pwr_pkg::*;
#(
    parameter int N = 32000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hw_pd_pin_i,
    input logic       pd_bit_i,
    input logic       status_rd_i,
    input logic       irq_en_i,
    input logic [2:0] state_o,
    input logic       irq_o,
    input logic       tx_en_o,
    input logic       logic_rst_o
);
    // Length of the current run of RESET_STRETCH cycles.
    int run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= 0;
        end else if (state_o == ST_STRETCH) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    a_r2_pin_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hw_pd_pin_i |=> (state_o == ST_HW_PD));

    a_r4_active_from_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_ACTIVE && $past(state_o) != ST_ACTIVE) |-> ($past(state_o) == ST_STRETCH));

    a_r4_stretch_length: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_ACTIVE && $past(state_o) == ST_STRETCH) |-> (run_len == N));

    a_r9_pin_release_to_gen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == ST_HW_PD && state_o != ST_HW_PD) |-> (state_o == ST_GEN_PD));

    a_r5_gen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_GEN_PD && pd_bit_i && !hw_pd_pin_i) |=> (state_o == ST_GEN_PD));

    a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && irq_en_i && !status_rd_i) |=> (irq_o || !irq_en_i));

    a_r3_tx_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_o |-> (state_o == ST_ACTIVE && !logic_rst_o));

endmodule

bind phy_pwr_ctrl pwr_ctrl_chk #(.N(STRETCH_CYCLES)) u_pwr_ctrl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_pd_pin_i (hw_pd_pin_i),
    .pd_bit_i    (pd_bit_i),
    .status_rd_i (status_rd_i),
    .irq_en_i    (irq_en_i),
    .state_o     (state_o),
    .irq_o       (irq_o),
    .tx_en_o     (tx_en_o),
    .logic_rst_o (logic_rst_o)
);

// File: tb/tb_phy_pwr_ctrl.sv
module tb_phy_pwr_ctrl;

    localparam int N = 20;
    localparam int S_ACT = 0, S_GEN = 1, S_ED = 2, S_HW = 3, S_STR = 4;

    logic clk = 1'b0;
    logic rst_n, pd_bit, ed_en, energy, pin, strap, soft_rst, irq_en, status_rd;
    logic pll_en, dp_en, tx_en, logic_rst, energy_on, irq;
    logic [2:0] state;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Reference model state
    int m_state, m_cnt;
    bit m_wait, m_srst, m_pdq, m_ev, m_strap;

    always #2 clk = ~clk;   // 250 MHz

    phy_pwr_ctrl #(.STRETCH_CYCLES(N)) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .pd_bit_i        (pd_bit),
        .ed_en_i         (ed_en),
        .line_energy_i   (energy),
        .hw_pd_pin_i     (pin),
        .strap_pll_off_i (strap),
        .soft_rst_i      (soft_rst),
        .irq_en_i        (irq_en),
        .status_rd_i     (status_rd),
        .pll_en_o        (pll_en),
        .dp_en_o         (dp_en),
        .tx_en_o         (tx_en),
        .logic_rst_o     (logic_rst),
        .energy_on_o     (energy_on),
        .irq_o           (irq),
        .state_o         (state)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Waits (at negedges) up to max cycles for state st; returns 1 if seen.
    task automatic wait_state(input int st, input int max, output bit seen);
        seen = 0;
        for (int i = 0; i < max && !seen; i++) begin
            @(negedge clk);
            if (state == 3'(st)) seen = 1;
        end
    endtask

    task automatic do_reset(input bit p, input bit s);
        rst_n = 1'b0; pin = p; strap = s;
        tick(4);
        rst_n = 1'b1;
    endtask

    function automatic int exp_en(input int st, input bit strp);
        bit pll, act;
        act = (st == S_ACT);
        pll = act || (st == S_STR) || (st == S_HW && !strp);
        return {pll, act, act, !act};
    endfunction

    // Steps the model by one clock edge with the currently driven inputs.
    task automatic model_step();
        int nx;
        bit enter_hw, wk, done;
        done = (m_state == S_STR) && (m_cnt == N - 1);
        nx = m_state;
        case (m_state)
            S_ACT: if (pin) nx = S_HW; else if (pd_bit) nx = S_GEN;
                   else if (ed_en && !energy) nx = S_ED;
            S_GEN: if (pin) nx = S_HW; else if (!pd_bit && !m_wait && !m_srst) nx = S_STR;
            S_ED:  if (pin) nx = S_HW; else if (pd_bit) nx = S_GEN;
                   else if (energy || !ed_en) nx = S_STR;
            S_HW:  if (!pin) nx = S_GEN;
            default: if (pin) nx = S_HW; else if (pd_bit) nx = S_GEN;
                   else if (done) nx = S_ACT;
        endcase
        enter_hw = (nx == S_HW) && (m_state != S_HW);
        wk = (m_state == S_ED) && (nx == S_STR) && energy;
        if (enter_hw) begin
            m_wait = 1; m_srst = m_strap;
        end else begin
            if (m_state == S_GEN && m_pdq && !pd_bit) m_wait = 0;
            if (soft_rst) m_srst = 0;
        end
        m_pdq = pd_bit;
        m_cnt = (m_state == S_STR) ? m_cnt + 1 : 0;
        if (wk) m_ev = 1; else if (status_rd) m_ev = 0;
        m_state = nx;
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_up();
    end

    initial begin
        bit seen;
        int n;
        pd_bit = 0; ed_en = 0; energy = 1; soft_rst = 0; irq_en = 1; status_rd = 0;
        do_reset(1'b0, 1'b1);

        // ---- R1/R3: reset state ----
        tick();
        chk("R1 state after reset", state, S_STR);
        chk("R3 logic reset in stretch", logic_rst, 1);
        chk("R3 pll on in stretch", pll_en, 1);
        chk("R3 datapath off in stretch", dp_en, 0);
        wait_state(S_ACT, N + 4, seen);
        chk("R4 reach ACTIVE", seen, 1);
        chk("R3 enables in ACTIVE", {pll_en, dp_en, tx_en, logic_rst}, 4'b1110);

        // ---- R5/R4: general power-down and exact stretch ----
        pd_bit = 1; tick();
        chk("R2 bit enters GEN_PD", state, S_GEN);
        chk("R3 enables in GEN_PD", {pll_en, dp_en, tx_en, logic_rst}, 4'b0001);
        tick(5);
        chk("R5 GEN_PD holds", state, S_GEN);
        pd_bit = 0; tick();
        chk("R5 clear leads to stretch", state, S_STR);
        n = 0;
        while (state == 3'(S_STR) && n < 1000) begin n++; tick(); end
        chk("R4 stretch length", n, N);
        chk("R4 ACTIVE after stretch", state, S_ACT);

        // ---- R6/R7/R8: energy detect ----
        ed_en = 1; energy = 0; tick();
        chk("R2 quiet enters ED_PD", state, S_ED);
        chk("R3 tx off in ED_PD", tx_en, 0);
        tick(8);
        chk("R7 no status without wake", energy_on, 0);
        energy = 1; status_rd = 1; tick();
        status_rd = 0;
        chk("R6 energy wakes", state, S_STR);
        chk("R7 wake beats read strobe", energy_on, 1);
        chk("R8 irq with mask set", irq, 1);
        irq_en = 0; #1;
        chk("R8 irq masked", irq, 0);
        irq_en = 1;
        wait_state(S_ACT, N + 4, seen);
        tick(10);
        chk("R6 stays ACTIVE with energy", state, S_ACT);
        chk("R7 status held", energy_on, 1);
        status_rd = 1; tick(); status_rd = 0;
        chk("R7 read clears status", energy_on, 0);
        chk("R8 irq follows clear", irq, 0);
        energy = 0; tick();
        chk("R6 ED_PD again", state, S_ED);
        ed_en = 0; tick();
        chk("R6 enable clear exits", state, S_STR);
        chk("R7 enable exit sets no status", energy_on, 0);
        energy = 1;
        wait_state(S_ACT, N + 4, seen);

        // ---- R2/R9/R10: pin with PLL-off strap ----
        pd_bit = 1; pin = 1; tick();
        chk("R2 pin outranks bit", state, S_HW);
        chk("R10 pll off in HW_PD", pll_en, 0);
        pin = 0; tick();
        chk("R9 pin release to GEN_PD", state, S_GEN);
        pd_bit = 0; tick(5);
        chk("R10 waits for software reset", state, S_GEN);
        soft_rst = 1; tick(); soft_rst = 0;
        wait_state(S_STR, 4, seen);
        chk("R10 exit after software reset", seen, 1);
        wait_state(S_ACT, N + 4, seen);

        // ---- R9: bit already clear at pin release ----
        pin = 1; tick();
        soft_rst = 1; tick(); soft_rst = 0;
        pin = 0; tick();
        chk("R9 GEN_PD after release", state, S_GEN);
        tick(5);
        chk("R9 zero bit is not a clear", state, S_GEN);
        pd_bit = 1; tick(); pd_bit = 0;
        wait_state(S_STR, 4, seen);
        chk("R9 exit after 1-0 step", seen, 1);
        wait_state(S_ACT, N + 4, seen);

        // ---- R12/R11/R10: strap capture ----
        strap = 0; pin = 1; tick();
        chk("R12 strap change ignored", pll_en, 0);
        rst_n = 0; tick(3); rst_n = 1; tick();
        chk("R11 boot into HW_PD", state, S_HW);
        chk("R10 pll kept with strap 0", pll_en, 1);
        pin = 0; tick();
        pd_bit = 1; tick(); pd_bit = 0;
        wait_state(S_STR, 4, seen);
        chk("R10 no software reset needed", seen, 1);

        // ---- random phase against the model ----
        void'($urandom(32'd2024));
        rst_n = 0; pin = 0; pd_bit = 0; strap = 1'($urandom % 2);
        tick(3);
        m_state = S_STR; m_cnt = 0; m_wait = 0; m_srst = 0; m_pdq = 0; m_ev = 0;
        m_strap = strap;
        rst_n = 1;
        model_step();
        for (int cyc = 0; cyc < 4000; cyc++) begin
            tick();
            chk("R2 state vs model", state, m_state);
            chk("R3 enables vs model", {pll_en, dp_en, tx_en, logic_rst}, exp_en(m_state, m_strap));
            chk("R7 status vs model", energy_on, m_ev);
            chk("R8 irq vs model", irq, m_ev & irq_en);
            if ($urandom % 40 == 0) pin = ~pin;
            if ($urandom % 20 == 0) pd_bit = ~pd_bit;
            if ($urandom % 50 == 0) ed_en = ~ed_en;
            if ($urandom % 8 == 0) energy = ~energy;
            if ($urandom % 30 == 0) irq_en = ~irq_en;
            soft_rst = ($urandom % 30 == 0);
            status_rd = ($urandom % 25 == 0);
            model_step();
        end
        finish_up();
    end

endmodule